// File: doc/BRIEF.md
# Serial-bus RTU frame checksum and address judge

This block sits behind a serial receiver and works on a frame that has already been collected into a byte buffer. After a start pulse it reads the frame through a synchronous read port, one byte at a time. Each byte goes through a bit-serial CRC-16 engine. The engine starts from all ones and uses the reflected polynomial 0xA001. The block also checks the receive-error flag and the frame length. When the run ends it gives exactly one verdict: drop the frame, act on it and answer, or act on it without answering because it is a broadcast.

The same CRC engine also seals outgoing replies. In generate mode the block runs every byte of a reply held in the buffer through the engine. It then presents the two checksum bytes in the order they must be sent on the line. Buffer storage and the decoding of function codes are handled elsewhere.

Top module: `mb_frame_check`

## Requirements
- R1: After reset `busy`, `verdict_valid` and `crc_valid` are all low.
- R2: In check mode, a start with `rx_bad` high gives a drop verdict (code 0) on the cycle after the start, whatever the buffer holds.
- R3: In check mode, a frame of fewer than 4 bytes gives a drop verdict on the cycle after the start. A 4-byte frame with a correct checksum is accepted.
- R4: The checksum covers bytes 0 to len-3 of the frame. The register starts at 0xFFFF and shifts right with polynomial 0xA001. Any mismatch in the last two bytes gives a drop verdict.
- R5: Byte len-2 must equal the low byte of the computed CRC and byte len-1 must equal the high byte. A frame with these two bytes swapped is dropped.
- R6: A frame that passes all checks and whose byte 0 equals `own_addr` gets code 1 (reply).
- R7: A frame that passes all checks and whose byte 0 is 0x00 gets code 2 (silent). This applies even when `own_addr` is also 0x00.
- R8: A frame that passes all checks and whose byte 0 is any other value gets code 0 (drop).
- R9: With the verdict, `payload_len` gives len-3 for codes 1 and 2, which is the frame without the address byte and the checksum. It gives 0 for code 0.
- R10: In generate mode the block runs all `frame_len` bytes through the CRC. It then pulses `crc_valid` for one cycle, with `crc_first` equal to the low byte and `crc_second` equal to the high byte.
- R11: Each accepted start gives exactly one one-cycle result strobe: `verdict_valid` in check mode, `crc_valid` in generate mode. `busy` is low while the strobe is high. A start that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run; sampled only while idle |
| mode_gen | input | 1 | 0 = check a received frame, 1 = compute a reply checksum |
| frame_len | input | LEN_W | Number of bytes in the buffer for this run (at most MAX_LEN) |
| rx_bad | input | 1 | The receiver saw a framing, parity or overrun error in this frame |
| own_addr | input | 8 | Station address that this node answers |
| buf_addr | output | AW | Read address to the frame buffer |
| buf_data | input | 8 | Read data, valid one cycle after `buf_addr` |
| busy | output | 1 | A run is in progress |
| verdict_valid | output | 1 | One-cycle strobe carrying the check result |
| verdict | output | 2 | 0 drop, 1 reply, 2 silent |
| payload_len | output | LEN_W | Frame length without the address and the checksum |
| crc_valid | output | 1 | One-cycle strobe carrying the reply checksum |
| crc_first | output | 8 | Checksum byte that goes first on the line (CRC low byte) |
| crc_second | output | 8 | Checksum byte that goes second on the line (CRC high byte) |

## Verification
The bench swaps the two checksum bytes. A design that compares them in big-endian order would accept that frame and drop every correct one. It sends frames of length 3 and 4 on either side of the undersize limit, and an off-by-one in that compare would either read past a short frame or reject the minimal valid frame. A valid frame with the error flag set tests whether the flag wins over a good checksum. Broadcast, own and foreign addresses, together with a start pulse while busy, would show a design that mixes up the verdict codes or gives two strobes for one run. Generate mode is checked against a known six-byte vector, so an engine with the wrong seed or polynomial fails even if the bench's model shares the same fault.

// File: rtl/mb_frame_pkg.sv
package mb_frame_pkg;
  typedef enum logic [1:0] {
    VD_DROP   = 2'd0,
    VD_REPLY  = 2'd1,
    VD_SILENT = 2'd2
  } verdict_e;

  localparam logic [7:0]  BCAST_ADDR = 8'h00;
  localparam logic [15:0] CRC_SEED   = 16'hFFFF;
  localparam logic [15:0] CRC_POLY   = 16'hA001;
  localparam int          MIN_FRAME  = 4;
endpackage

// File: rtl/mb_crc_engine.sv
module mb_crc_engine
  import mb_frame_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        init,
  input  logic        load,
  input  logic [7:0]  din,
  input  logic        shift,
  output logic [15:0] crc
);
  always_ff @(posedge clk) begin
    if (rst || init) begin
      crc <= CRC_SEED;
    end else if (load) begin
      crc <= crc ^ {8'h00, din};
    end else if (shift) begin
      crc <= crc[0] ? ((crc >> 1) ^ CRC_POLY) : (crc >> 1);
    end
  end
endmodule

// File: rtl/mb_addr_judge.sv
module mb_addr_judge
  import mb_frame_pkg::*;
(
  input  logic       crc_ok,
  input  logic [7:0] dest,
  input  logic [7:0] own_addr,
  output verdict_e   code
);
  always_comb begin
    if (!crc_ok)                 code = VD_DROP;
    else if (dest == BCAST_ADDR) code = VD_SILENT;
    else if (dest == own_addr)   code = VD_REPLY;
    else                         code = VD_DROP;
  end
endmodule

// File: rtl/mb_frame_check.sv
module mb_frame_check
  import mb_frame_pkg::*;
#(
  parameter int MAX_LEN = 256,
  parameter int LEN_W   = $clog2(MAX_LEN + 1),
  parameter int AW      = $clog2(MAX_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             mode_gen,
  input  logic [LEN_W-1:0] frame_len,
  input  logic             rx_bad,
  input  logic [7:0]       own_addr,
  output logic [AW-1:0]    buf_addr,
  input  logic [7:0]       buf_data,
  output logic             busy,
  output logic             verdict_valid,
  output logic [1:0]       verdict,
  output logic [LEN_W-1:0] payload_len,
  output logic             crc_valid,
  output logic [7:0]       crc_first,
  output logic [7:0]       crc_second
);
  localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(MIN_FRAME);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_LOAD, S_SHIFT, S_DONE} state_e;

  state_e           state;
  logic [LEN_W-1:0] idx, len_q, crc_end;
  logic [2:0]       bitcnt;
  logic             is_gen;
  logic [7:0]       dest_q, wire0_q, wire1_q;
  logic [15:0]      crc;
  logic             eng_init, eng_load, eng_shift, last_byte, crc_ok;
  verdict_e         judged;

  // A start is refused outright when it is a check of a flagged or short frame,
  // or a checksum request for an empty reply.
  logic early_drop, empty_gen, accept;
  assign early_drop = !mode_gen && (rx_bad || frame_len < LEN_MIN);
  assign empty_gen  = mode_gen && (frame_len == '0);
  assign accept     = (state == S_IDLE) && start;

  assign crc_end   = is_gen ? len_q : (len_q - LEN_W'(2));
  assign last_byte = (idx == len_q - LEN_W'(1));
  assign eng_init  = accept;
  assign eng_load  = (state == S_LOAD) && (idx < crc_end);
  assign eng_shift = (state == S_SHIFT);
  assign crc_ok    = (wire0_q == crc[7:0]) && (wire1_q == crc[15:8]);
  assign busy      = (state != S_IDLE);
  assign buf_addr  = idx[AW-1:0];

  mb_crc_engine u_crc (
    .clk   (clk),
    .rst   (rst),
    .init  (eng_init),
    .load  (eng_load),
    .din   (buf_data),
    .shift (eng_shift),
    .crc   (crc)
  );

  mb_addr_judge u_judge (
    .crc_ok   (crc_ok),
    .dest     (dest_q),
    .own_addr (own_addr),
    .code     (judged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= S_IDLE;
      idx           <= '0;
      len_q         <= '0;
      bitcnt        <= '0;
      is_gen        <= 1'b0;
      dest_q        <= '0;
      wire0_q       <= '0;
      wire1_q       <= '0;
      verdict_valid <= 1'b0;
      verdict       <= VD_DROP;
      payload_len   <= '0;
      crc_valid     <= 1'b0;
      crc_first     <= '0;
      crc_second    <= '0;
    end else begin
      verdict_valid <= 1'b0;
      crc_valid     <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept) begin
            if (early_drop) begin
              verdict_valid <= 1'b1;
              verdict       <= VD_DROP;
              payload_len   <= '0;
            end else if (empty_gen) begin
              crc_valid  <= 1'b1;
              crc_first  <= CRC_SEED[7:0];
              crc_second <= CRC_SEED[15:8];
            end else begin
              idx    <= '0;
              len_q  <= frame_len;
              is_gen <= mode_gen;
              state  <= S_ADDR;
            end
          end
        end
        S_ADDR: state <= S_LOAD;
        S_LOAD: begin
          if (idx == '0) dest_q <= buf_data;
          if (idx < crc_end) begin
            bitcnt <= '0;
            state  <= S_SHIFT;
          end else begin
            if (last_byte) wire1_q <= buf_data;
            else           wire0_q <= buf_data;
            if (last_byte) state <= S_DONE;
            else begin
              idx   <= idx + LEN_W'(1);
              state <= S_ADDR;
            end
          end
        end
        S_SHIFT: begin
          bitcnt <= bitcnt + 3'd1;
          if (bitcnt == 3'd7) begin
            if (last_byte) state <= S_DONE;
            else begin
              idx   <= idx + LEN_W'(1);
              state <= S_ADDR;
            end
          end
        end
        S_DONE: begin
          state <= S_IDLE;
          if (is_gen) begin
            crc_valid  <= 1'b1;
            crc_first  <= crc[7:0];
            crc_second <= crc[15:8];
          end else begin
            verdict_valid <= 1'b1;
            verdict       <= judged;
            payload_len   <= (judged == VD_DROP) ? '0 : (len_q - LEN_W'(3));
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mb_frame_check_sva.sv
module mb_frame_check_sva #(
  parameter int LEN_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             mode_gen,
  input logic             rx_bad,
  input logic [LEN_W-1:0] frame_len,
  input logic             busy,
  input logic             verdict_valid,
  input logic [1:0]       verdict,
  input logic [LEN_W-1:0] payload_len,
  input logic             crc_valid
);
  a_r2_flag_drops: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !mode_gen && rx_bad) |=> (verdict_valid && verdict == 2'd0));

  a_r3_short_drops: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !mode_gen && frame_len < LEN_W'(4)) |=> (verdict_valid && verdict == 2'd0));

  a_r9_drop_len_zero: assert property (@(posedge clk) disable iff (rst)
    (verdict_valid && verdict == 2'd0) |-> (payload_len == '0));

  a_r10_crc_pulse: assert property (@(posedge clk) disable iff (rst)
    crc_valid |=> !crc_valid);

  a_r11_verdict_pulse: assert property (@(posedge clk) disable iff (rst)
    verdict_valid |=> !verdict_valid);

  a_r11_idle_at_strobe: assert property (@(posedge clk) disable iff (rst)
    (verdict_valid || crc_valid) |-> !busy);

  a_r11_one_kind: assert property (@(posedge clk) disable iff (rst)
    $countones({verdict_valid, crc_valid}) <= 1);

  a_r11_legal_code: assert property (@(posedge clk) disable iff (rst)
    verdict_valid |-> (verdict != 2'd3));
endmodule

bind mb_frame_check mb_frame_check_sva #(.LEN_W(LEN_W)) u_sva (
  .clk           (clk),
  .rst           (rst),
  .start         (start),
  .mode_gen      (mode_gen),
  .rx_bad        (rx_bad),
  .frame_len     (frame_len),
  .busy          (busy),
  .verdict_valid (verdict_valid),
  .verdict       (verdict),
  .payload_len   (payload_len),
  .crc_valid     (crc_valid)
);

// File: tb/test_mb_frame_check.sv
module test_mb_frame_check;
  localparam int MAX_LEN = 256;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);
  localparam int AW      = $clog2(MAX_LEN);
  localparam logic [7:0] OWN = 8'h11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, mode_gen = 1'b0, rx_bad = 1'b0;
  logic [LEN_W-1:0] frame_len = '0;
  logic [7:0] own_addr = OWN;
  logic [AW-1:0] buf_addr;
  logic [7:0] buf_data;
  logic busy, verdict_valid, crc_valid;
  logic [1:0] verdict;
  logic [LEN_W-1:0] payload_len;
  logic [7:0] crc_first, crc_second;

  logic [7:0] mem [MAX_LEN];
  int checks = 0, errors = 0, cycles = 0;

  always #10 clk = ~clk;
  always_ff @(posedge clk) buf_data <= mem[buf_addr];

  mb_frame_check #(.MAX_LEN(MAX_LEN)) i_mb_frame_check (
    .clk(clk), .rst(rst), .start(start), .mode_gen(mode_gen),
    .frame_len(frame_len), .rx_bad(rx_bad), .own_addr(own_addr),
    .buf_addr(buf_addr), .buf_data(buf_data), .busy(busy),
    .verdict_valid(verdict_valid), .verdict(verdict), .payload_len(payload_len),
    .crc_valid(crc_valid), .crc_first(crc_first), .crc_second(crc_second)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {8'h00, mem[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 16'hA001) : (c >> 1);
    end
    return c;
  endfunction

  // Fill a frame of n bytes: address, body bytes, then a valid checksum.
  task automatic build(input int n, input logic [7:0] dest, input logic [7:0] seed);
    logic [15:0] c;
    mem[0] = dest;
    for (int i = 1; i < n - 2; i++) mem[i] = seed + 8'(i * 37);
    c = ref_crc(n - 2);
    mem[n-2] = c[7:0];
    mem[n-1] = c[15:8];
  endtask

  // Pulse start; watch until a strobe and a few idle cycles after it.
  task automatic fire(input bit gen, input int n, input bit bad, input bit extra_start,
                      output int nv, output int nc, output int code, output int plen,
                      output int c0, output int c1);
    nv = 0; nc = 0; code = -1; plen = -1; c0 = -1; c1 = -1;
    @(negedge clk);
    mode_gen = gen; frame_len = LEN_W'(n); rx_bad = bad; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 4000; t++) begin
      if (t == 3 && extra_start) begin
        mode_gen = ~gen; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (verdict_valid) begin nv++; code = verdict; plen = payload_len; end
      if (crc_valid) begin nc++; c0 = crc_first; c1 = crc_second; end
      if ((nv + nc) > 0 && t > 12 && !busy) break;
      @(negedge clk);
    end
    start = 1'b0; rx_bad = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 busy", busy, 0);
    check("R1 verdict_valid", verdict_valid, 0);
    check("R1 crc_valid", crc_valid, 0);
  endtask

  task automatic t_addr_kinds;
    int nv, nc, code, plen, c0, c1;
    build(8, OWN, 8'h03);
    fire(0, 8, 0, 0, nv, nc, code, plen, c0, c1);
    check("R6 own addr code", code, 1);
    check("R9 payload len", plen, 5);
    check("R11 single strobe", nv, 1);
    build(10, 8'h00, 8'h41);
    fire(0, 10, 0, 0, nv, nc, code, plen, c0, c1);
    check("R7 broadcast code", code, 2);
    check("R9 broadcast len", plen, 7);
    own_addr = 8'h00;
    build(6, 8'h00, 8'h19);
    fire(0, 6, 0, 0, nv, nc, code, plen, c0, c1);
    check("R7 broadcast wins own 0", code, 2);
    own_addr = OWN;
    build(7, 8'h22, 8'h55);
    fire(0, 7, 0, 0, nv, nc, code, plen, c0, c1);
    check("R8 foreign code", code, 0);
    check("R9 drop len", plen, 0);
  endtask

  task automatic t_crc_faults;
    int nv, nc, code, plen, c0, c1;
    logic [7:0] tmp;
    build(9, OWN, 8'h77);
    mem[3] = mem[3] ^ 8'h10;
    fire(0, 9, 0, 0, nv, nc, code, plen, c0, c1);
    check("R4 corrupt body dropped", code, 0);
    build(9, OWN, 8'h12);
    mem[8] = mem[8] ^ 8'h01;
    fire(0, 9, 0, 0, nv, nc, code, plen, c0, c1);
    check("R4 corrupt crc dropped", code, 0);
    build(9, OWN, 8'h12);
    tmp = mem[7]; mem[7] = mem[8]; mem[8] = tmp;
    fire(0, 9, 0, 0, nv, nc, code, plen, c0, c1);
    check("R5 swapped crc dropped", code, (mem[7] == mem[8]) ? 1 : 0);
  endtask

  task automatic t_flag_and_size;
    int nv, nc, code, plen, c0, c1;
    build(8, OWN, 8'h03);
    fire(0, 8, 1, 0, nv, nc, code, plen, c0, c1);
    check("R2 error flag dropped", code, 0);
    check("R2 one strobe", nv, 1);
    build(3, OWN, 8'h00);
    fire(0, 3, 0, 0, nv, nc, code, plen, c0, c1);
    check("R3 len 3 dropped", code, 0);
    build(4, OWN, 8'h00);
    fire(0, 4, 0, 0, nv, nc, code, plen, c0, c1);
    check("R3 len 4 accepted", code, 1);
    check("R9 len 4 payload", plen, 1);
  endtask

  task automatic t_generate;
    int nv, nc, code, plen, c0, c1;
    logic [15:0] c;
    mem[0] = 8'h01; mem[1] = 8'h03; mem[2] = 8'h00;
    mem[3] = 8'h00; mem[4] = 8'h00; mem[5] = 8'h01;
    fire(1, 6, 0, 0, nv, nc, code, plen, c0, c1);
    check("R10 known vector first", c0, 8'h84);
    check("R10 known vector second", c1, 8'h0A);
    check("R10 no verdict", nv, 0);
    build(20, OWN, 8'hA5);
    c = ref_crc(20);
    fire(1, 20, 0, 0, nv, nc, code, plen, c0, c1);
    check("R10 gen first", c0, c[7:0]);
    check("R10 gen second", c1, c[15:8]);
    check("R10 one strobe", nc, 1);
  endtask

  task automatic t_busy_start;
    int nv, nc, code, plen, c0, c1;
    build(12, OWN, 8'h3C);
    fire(0, 12, 0, 1, nv, nc, code, plen, c0, c1);
    check("R11 busy start verdicts", nv, 1);
    check("R11 busy start no crc", nc, 0);
    check("R11 busy start code", code, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst = 1'b0;
    @(negedge clk);
    t_addr_kinds;
    t_crc_faults;
    t_flag_and_size;
    t_generate;
    t_busy_start;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule